// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a faster interface clock. The divide ratio is programmed in interface-clock units with a sixteenth-cycle fraction. The block runs on a tick at twice the interface rate, so every output edge falls on a half-cycle position. For an integer or half-integer ratio every output period is exact. For any other ratio a small phase accumulator decides, period by period, whether to stretch the period by one tick. Individual periods then dither by one tick while the long-run average equals the programmed ratio.

Inside each period, a rise position and a fall position (in ticks), both shifted by a common offset, shape the clock waveform. A one-tick strobe marks the start of every period. All settings are sampled only when a new period begins, so software can rewrite them at any time without producing a torn period.

Top module: `pixclk_frac_div`

## Requirements
- R1: `ratio_i` is unsigned, with its low 4 bits the fraction in 1/16 interface cycle; one tick is half an interface cycle, so a half-integer ratio such as 0x028 gives a period of exactly 5 ticks every period.
- R2: With a fraction of 0, every period is exactly 2 × (integer part) ticks long.
- R3: With any other ratio R (clamped per R4), each period is floor(R/8) or floor(R/8)+1 ticks long. The total length of the first k periods after reset is k·floor(R/8) + floor((k−1)·(R mod 8)/8) ticks.
- R4: A ratio below 16 (less than one interface cycle) behaves as 16, which gives a 2-tick period.
- R5: `start_o` is high for exactly one tick at the start of every period; the first strobe comes on the first tick after reset is released.
- R6: With u = `rise_i`+`shift_i` and d = `fall_i`+`shift_i`, in the tick j ticks after a strobe (the strobe tick is j = 0) `pclk_o` is high when u<d and u≤j<d, or when u>d and (j≥u or j<d).
- R7: When u equals d, `pclk_o` stays low for the whole period.
- R8: New values on `ratio_i`, `rise_i`, `fall_i` and `shift_i` take effect only at the next strobe; the period in progress keeps its length and waveform.
- R9: A synchronous reset drives `pclk_o` and `start_o` low and clears the accumulator, so the first period after reset is floor(R/8) ticks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the interface rate |
| rst | input | 1 | Synchronous active-high reset |
| ratio_i | input | 12 | Period ratio, 8 integer bits and 4 fraction bits |
| rise_i | input | 10 | Rise position in ticks from period start |
| fall_i | input | 10 | Fall position in ticks from period start |
| shift_i | input | 10 | Offset in ticks added to both edge positions |
| pclk_o | output | 1 | Pixel clock |
| start_o | output | 1 | One-tick period-start strobe |

## Verification
The bench sweeps every ratio from 0 to 215 and measures each of the first periods after reset against the cumulative-length formula. A design that updated the accumulator wrongly would show periods that are too long or too short, or an average that drifts; a design that failed to clamp would show periods shorter than 2 ticks. Every tick of every period is compared with the rise/fall window, including cases where the window wraps and cases where it is empty. These catch offset errors, swapped comparisons and a clock left high when both positions are equal. A mid-period rewrite of the settings checks that the running period keeps its old length and shape and that the new ones start exactly at the next strobe.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  // Ratio in 1/2**fw cycle units; anything below one cycle is raised to one.
  function automatic int unsigned clamp_ratio(int unsigned r, int unsigned fw);
    int unsigned one;
    one = 32'd1 << fw;
    return (r < one) ? one : r;
  endfunction

  // Whole ticks (half cycles) in the clamped ratio.
  function automatic int unsigned base_ticks(int unsigned r, int unsigned fw);
    return clamp_ratio(r, fw) >> (fw - 1);
  endfunction

  // Sub-tick remainder of the clamped ratio, in 1/2**fw cycle units.
  function automatic int unsigned sub_tick(int unsigned r, int unsigned fw);
    return clamp_ratio(r, fw) & ((32'd1 << (fw - 1)) - 32'd1);
  endfunction

  // High window: [u,d) when u<d, wrapping when u>d, empty when u==d.
  function automatic logic in_window(int unsigned j, int unsigned u, int unsigned d);
    if (u < d)      return (j >= u) && (j < d);
    else if (u > d) return (j >= u) || (j < d);
    else            return 1'b0;
  endfunction

endpackage

// File: rtl/pcd_accum.sv
module pcd_accum #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  localparam int RW    = INT_W + FRAC_W,
  localparam int AW    = FRAC_W - 1,
  localparam int CNT_W = INT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RW-1:0]    ratio_i,
  output logic [CNT_W-1:0] len_o,
  output logic [AW-1:0]    acc_o,
  output logic             stretch_o
);
  import pcd_pkg::*;

  logic [AW-1:0]    acc_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] base;
  logic [AW-1:0]    frac;
  logic [AW:0]      sum;

  always_comb begin
    base = CNT_W'(base_ticks(32'(ratio_i), FRAC_W));
    frac = AW'(sub_tick(32'(ratio_i), FRAC_W));
    sum  = {1'b0, acc_q} + {1'b0, frac};
  end

  assign stretch_o = !rst && sum[AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      len_q <= base;
    end else if (load) begin
      acc_q <= sum[AW-1:0];
      len_q <= base + CNT_W'(sum[AW]);
    end
  end

  assign len_o = len_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/pcd_phase.sv
module pcd_phase #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pcd_edge.sv
module pcd_edge #(
  parameter int POS_W = 10,
  localparam int EW   = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [POS_W-1:0] rise_i,
  input  logic [POS_W-1:0] fall_i,
  input  logic [POS_W-1:0] shift_i,
  input  logic [POS_W-1:0] cnt_i,
  output logic [EW-1:0]    up_eff_o,
  output logic [EW-1:0]    dn_eff_o,
  output logic             pclk_o,
  output logic             start_o
);
  import pcd_pkg::*;

  logic [EW-1:0] up_q, dn_q;
  logic          pclk_q, start_q;
  logic          hi_now;

  assign hi_now = in_window(32'(cnt_i), 32'(up_q), 32'(dn_q));

  always_ff @(posedge clk) begin
    if (load) begin
      up_q <= {1'b0, rise_i} + {1'b0, shift_i};
      dn_q <= {1'b0, fall_i} + {1'b0, shift_i};
    end
    if (rst) begin
      pclk_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      pclk_q  <= hi_now;
      start_q <= (cnt_i == '0);
    end
  end

  assign up_eff_o = up_q;
  assign dn_eff_o = dn_q;
  assign pclk_o   = pclk_q;
  assign start_o  = start_q;
endmodule

// File: rtl/pixclk_frac_div.sv
module pixclk_frac_div #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  localparam int RW    = INT_W + FRAC_W,
  localparam int AW    = FRAC_W - 1,
  localparam int CNT_W = INT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RW-1:0]    ratio_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  input  logic [CNT_W-1:0] shift_i,
  output logic             pclk_o,
  output logic             start_o
);
  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0] cur_len;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    acc;
  logic             stretch;
  logic             wrap;
  logic             period_load;
  logic [CNT_W:0]   up_eff, dn_eff;

  assign period_load = rst || wrap;

  pcd_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst(rst), .load(period_load), .ratio_i(ratio_i),
    .len_o(cur_len), .acc_o(acc), .stretch_o(stretch)
  );

  pcd_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .len_i(cur_len), .cnt_o(cnt), .wrap_o(wrap)
  );

  pcd_edge #(.POS_W(CNT_W)) u_edge (
    .clk(clk), .rst(rst), .load(period_load),
    .rise_i(rise_i), .fall_i(fall_i), .shift_i(shift_i), .cnt_i(cnt),
    .up_eff_o(up_eff), .dn_eff_o(dn_eff), .pclk_o(pclk_o), .start_o(start_o)
  );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  localparam int RW    = INT_W + FRAC_W,
  localparam int AW    = FRAC_W - 1,
  localparam int CNT_W = INT_W + 2
) (
  input logic             clk,
  input logic             rst,
  input logic [RW-1:0]    ratio_i,
  input logic             period_load,
  input logic             stretch,
  input logic [CNT_W-1:0] cur_len,
  input logic [CNT_W-1:0] cnt,
  input logic [AW-1:0]    acc,
  input logic [CNT_W:0]   up_eff,
  input logic [CNT_W:0]   dn_eff,
  input logic             pclk_o,
  input logic             start_o
);
  import pcd_pkg::*;

  // R9: the tick after reset has a low clock, no strobe, a cleared accumulator
  p_reset_state_r9: assert property (@(posedge clk)
    $past(rst) |-> (!pclk_o && !start_o && acc == '0));

  // R3: a freshly loaded period is the whole-tick length or one tick longer
  p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (period_load && !rst) |=>
      ((32'(cur_len) == base_ticks(32'($past(ratio_i)), FRAC_W)) ||
       (32'(cur_len) == base_ticks(32'($past(ratio_i)), FRAC_W) + 1)));

  // R3: an accumulator overflow stretches the next period by exactly one tick
  p_stretch_r3: assert property (@(posedge clk) disable iff (rst)
    (period_load && stretch) |=>
      (32'(cur_len) == base_ticks(32'($past(ratio_i)), FRAC_W) + 1));

  // R4: no period is ever shorter than two ticks, the phase stays inside it
  p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_len >= CNT_W'(2)) && (cnt < cur_len));

  // R5: a strobe follows only a tick whose phase was zero
  p_strobe_phase_r5: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ($past(cnt) == '0));

  // R7: an empty window keeps the clock low on the following tick
  p_empty_low_r7: assert property (@(posedge clk) disable iff (rst)
    (up_eff == dn_eff) |=> !pclk_o);

  // R8: the active edge settings change only at a period load
  p_hold_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    !period_load |=> ($stable(up_eff) && $stable(dn_eff) && $stable(cur_len)));
endmodule

bind pixclk_frac_div pcd_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_pcd_checker (
  .clk(clk), .rst(rst), .ratio_i(ratio_i), .period_load(period_load),
  .stretch(stretch), .cur_len(cur_len), .cnt(cnt), .acc(acc),
  .up_eff(up_eff), .dn_eff(dn_eff), .pclk_o(pclk_o), .start_o(start_o)
);

// File: tb/test_pixclk_frac_div.sv
`timescale 1ns/1ps
module test_pixclk_frac_div;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [11:0] ratio_i = 12'd16;
  logic [9:0]  rise_i = '0, fall_i = '0, shift_i = '0;
  logic        pclk_o, start_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pixclk_frac_div i_pixclk_frac_div (
    .clk(clk), .rst(rst), .ratio_i(ratio_i), .rise_i(rise_i),
    .fall_i(fall_i), .shift_i(shift_i), .pclk_o(pclk_o), .start_o(start_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit win(int j, int u, int d);
    if (u < d) return (j >= u && j < d);
    if (u > d) return (j >= u || j < d);
    return 1'b0;
  endfunction

  // Length of period k after reset for a constant ratio r (clamped below 16).
  function automatic int per_len(int r, int k);
    int rc, b, f, c1, c0;
    rc = (r < 16) ? 16 : r;
    b  = rc / 8;
    f  = rc % 8;
    c1 = (k + 1) * b + ((k > 0) ? (k * f) / 8 : 0);
    c0 = k * b + ((k > 1) ? ((k - 1) * f) / 8 : 0);
    return c1 - c0;
  endfunction

  function automatic string len_tag(int r);
    if (r < 16) return "R4 clamp";
    if (r % 16 == 0) return "R2 integer period";
    if (r % 8 == 0) return "R1 half-integer period";
    return "R3 dithered period";
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk(pclk_o == 1'b0 && start_o == 1'b0, "R9 reset outputs low", {pclk_o, start_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(start_o == 1'b1, "R5 first strobe one tick after reset", start_o, 1);
  endtask

  // Runs nper periods from the first strobe; the strobe tick is already sampled.
  task automatic run_sweep(input int r, input int u, input int d, input int o, input int nper);
    int j, p, seen;
    p = 0; j = 0; seen = 0;
    while (p < nper) begin
      chk(pclk_o == win(j, u + o, d + o),
          (u == d) ? "R7 empty window low" : "R6 window shape", pclk_o, win(j, u + o, d + o));
      @(negedge clk);
      j++;
      seen++;
      if (start_o) begin
        chk(j == per_len(r, p), (p == 0) ? "R9 first period" : len_tag(r), j, per_len(r, p));
        p++;
        j = 0;
      end
      if (seen > 4000) begin
        chk(1'b0, "R5 strobe missing", 0, 1);
        p = nper;
      end
    end
  endtask

  initial begin
    // Sweep every ratio from below the clamp up to 215.
    for (int r = 0; r < 216; r++) begin
      int u, d, o;
      u = r % 4;
      d = (r % 7 == 0) ? u : (r % 4) + (r / 16) + (r % 3);
      o = r % 2;
      if (r % 5 == 0) begin
        u = (r / 16) + 2;
        d = 1;
      end
      ratio_i = 12'(r); rise_i = 10'(u); fall_i = 10'(d); shift_i = 10'(o);
      do_reset();
      run_sweep(r, u, d, o, 9);
    end

    // Mid-period rewrite: old length and shape hold until the next strobe (R8).
    begin
      int j, len0;
      ratio_i = 12'd80; rise_i = 10'd0; fall_i = 10'd5; shift_i = 10'd0;
      do_reset();
      j = 0;
      while (j < 2) begin
        chk(pclk_o == win(j, 0, 5), "R8 before rewrite", pclk_o, win(j, 0, 5));
        @(negedge clk); j++;
      end
      ratio_i = 12'd96; rise_i = 10'd3; fall_i = 10'd6; shift_i = 10'd2;
      len0 = 0;
      while (!start_o && j < 50) begin
        chk(pclk_o == win(j, 0, 5), "R8 old window kept", pclk_o, win(j, 0, 5));
        @(negedge clk); j++;
      end
      chk(j == 10, "R8 old period length kept", j, 10);
      j = 0;
      while (j < 12) begin
        chk(pclk_o == win(j, 5, 8), "R8 new window at strobe", pclk_o, win(j, 5, 8));
        @(negedge clk); j++;
        if (start_o) len0 = j;
      end
      chk(len0 == 12, "R8 new period length", len0, 12);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R5 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule